// File: doc/BRIEF.md
# Multi-Queue Variable-Width Buffer

This block splits a single on-chip word array into as many as four independent first-in first-out queues. A controller sets each queue's length and its word width with configuration commands. From then on the block keeps the read and write pointers and the occupancy of every queue by itself, and it reports when a queue is full or empty. The bases of the queues inside the array follow from the programmed lengths, so the controller never handles addresses.

Every command follows the same handshake. The controller presents an opcode, a queue number and a 32-bit bus word, and holds `cmd_valid` high. The buffer latches all three and raises `cmd_ack`. The controller then releases the bus by dropping `cmd_valid`. The buffer carries out the operation on the next edge and pulses `rdy` for one cycle. During that cycle it also presents a result code and, for a retrieve, the data word. A store keeps only the configured number of low bits. A retrieve returns the word right-justified, with zeros in the upper bits. A store to a full queue or a retrieve from an empty queue is refused and reported.

Top module: `mqbuf`

## Requirements
- R1: The handshake has fixed timing. `cmd_ack` is high in the cycle after the edge that samples `cmd_valid` high in idle, and it stays high while `cmd_valid` stays high. `rdy` is high for exactly one cycle: the cycle after the edge that sees `cmd_valid` low while `cmd_ack` is high. `cmd_ack` and `rdy` are never high together.
- R2: `cmd_op` 0 configures the queue named by `cmd_q`. Its length is taken from `bus_in[15:0]` and its width in bits from `bus_in[21:16]`. The command is accepted (`err_code` 0) when the width is between 4 and 32 inclusive and the sum of all queue lengths, including the new one, is at most the array depth (64). An accepted configuration empties every queue.
- R3: A configuration with a width outside 4..32, or whose lengths would sum to more than the depth, gives `err_code` 3. The previous length and width of every queue are kept, and so is the content of every queue.
- R4: `cmd_op` 1 stores the bus word into queue `cmd_q`. `cmd_op` 2 retrieves the oldest word of that queue onto `bus_out`. Each queue keeps first-in first-out order independently of the others. `bus_out` changes only on a successful retrieve.
- R5: A stored word has every bit at and above the queue's width cleared. A retrieved word is right-justified, so `bus_out` bits at and above that width are 0.
- R6: `q_full[i]` is high when queue i holds as many words as its length. `q_empty[i]` is high when queue i holds no words.
- R7: A store to a full queue gives `err_code` 1. It writes nothing and leaves the occupancy unchanged.
- R8: A retrieve from an empty queue gives `err_code` 2. It leaves `bus_out` and the pointers unchanged.
- R9: `cmd_op` 3 empties every queue and keeps every length and width.
- R10: After reset, `cmd_ack` and `rdy` are low and every queue has length 0. Every queue therefore shows both full and empty, and a store to any queue is refused with code 1.
- R11: The pointers wrap at the queue's length, so a queue keeps its order through many fill and drain rounds.
- R12: `err` is high only in the `rdy` cycle, and only when `err_code` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; held until `cmd_ack` is seen |
| cmd_op | input | 2 | 0 configure, 1 store, 2 retrieve, 3 clear |
| cmd_q | input | 2 | Target queue |
| bus_in | input | 32 | Store data, or configuration fields |
| cmd_ack | output | 1 | Command latched |
| rdy | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with a refusal or a rejected configuration |
| err_code | output | 2 | 0 ok, 1 full, 2 empty, 3 bad configuration; valid with `rdy` |
| bus_out | output | 32 | Retrieved word, right-justified |
| q_full | output | 4 | Per-queue full flag |
| q_empty | output | 4 | Per-queue empty flag |

## Verification
Every command has the same timing. `cmd_ack` is due one edge after `cmd_valid` is raised. `rdy`, `err_code`, `bus_out` and the full and empty flags are all due one edge after `cmd_valid` is released. `rdy` falls again on the edge after that. The bench drives inputs at falling edges and samples exactly at those three points, in every transaction. In one case it holds `cmd_valid` high for extra cycles to show that `rdy` waits for the release. After `cmd_valid` is released it also inverts the bus word, which proves that the latched copy is the one used.

// File: rtl/mqbuf.sv
module mqbuf #(
  parameter int NQ    = 4,
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int MINW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [1:0]      cmd_q,
  input  logic [DW-1:0]   bus_in,
  output logic            cmd_ack,
  output logic            rdy,
  output logic            err,
  output logic [1:0]      err_code,
  output logic [DW-1:0]   bus_out,
  output logic [NQ-1:0]   q_full,
  output logic [NQ-1:0]   q_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int WW = $clog2(DW + 1);
  localparam logic [1:0] OP_CFG = 2'd0, OP_PUSH = 2'd1, OP_POP = 2'd2, OP_CLR = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_DONE} st_t;
  st_t state;

  logic [1:0]    op_l, q_l, code_r;
  logic [DW-1:0] dat_l, out_r;
  logic [LW-1:0] len [NQ];
  logic [WW-1:0] wid [NQ];
  logic [AW-1:0] rp  [NQ];
  logic [AW-1:0] wp  [NQ];
  logic [LW-1:0] cnt [NQ];
  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] base [NQ];
  logic [17:0]   tot;

  wire [15:0]   new_len = dat_l[15:0];
  wire [5:0]    new_w   = dat_l[21:16];
  wire          cfg_ok  = new_w >= 6'(MINW) && new_w <= 6'(DW) && tot <= 18'(DEPTH);
  wire          exec    = state == S_ACK && !cmd_valid;
  wire [LW-1:0] lq      = len[q_l];
  wire [LW-1:0] cq      = cnt[q_l];
  wire          full_q  = cq == lq;
  wire          empty_q = cq == '0;
  wire [AW-1:0] waddr   = AW'(base[q_l] + LW'(wp[q_l]));
  wire [AW-1:0] raddr   = AW'(base[q_l] + LW'(rp[q_l]));
  wire [DW-1:0] mask_q  = (wid[q_l] >= WW'(DW)) ? '1 : ((DW'(1) << wid[q_l]) - DW'(1));

  always_comb begin
    base[0] = '0;
    for (int i = 1; i < NQ; i++) base[i] = base[i-1] + len[i-1];
    tot = 18'(new_len);
    for (int i = 0; i < NQ; i++)
      if (i != int'(q_l)) tot = tot + 18'(len[i]);
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [LW-1:0] l);
    logic [LW-1:0] n;
    n = LW'(p) + LW'(1);
    return (n == l) ? '0 : AW'(n);
  endfunction

  always_ff @(posedge clk)
    if (exec && op_l == OP_PUSH && !full_q) mem[waddr] <= dat_l & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_l   <= '0;
      q_l    <= '0;
      dat_l  <= '0;
      code_r <= '0;
      out_r  <= '0;
      for (int i = 0; i < NQ; i++) begin
        len[i] <= '0; wid[i] <= '0; rp[i] <= '0; wp[i] <= '0; cnt[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_l  <= cmd_op;
          q_l   <= cmd_q;
          dat_l <= bus_in;
          state <= S_ACK;
        end
        S_ACK: if (!cmd_valid) begin
          state <= S_DONE;
          code_r <= 2'd0;
          case (op_l)
            OP_CFG: if (cfg_ok) begin
              len[q_l] <= LW'(new_len);
              wid[q_l] <= WW'(new_w);
              for (int i = 0; i < NQ; i++) begin
                rp[i] <= '0; wp[i] <= '0; cnt[i] <= '0;
              end
            end else code_r <= 2'd3;
            OP_PUSH: if (full_q) code_r <= 2'd1;
            else begin
              wp[q_l]  <= bump(wp[q_l], lq);
              cnt[q_l] <= cq + LW'(1);
            end
            OP_POP: if (empty_q) code_r <= 2'd2;
            else begin
              out_r    <= mem[raddr] & mask_q;
              rp[q_l]  <= bump(rp[q_l], lq);
              cnt[q_l] <= cq - LW'(1);
            end
            default: for (int i = 0; i < NQ; i++) begin
              rp[i] <= '0; wp[i] <= '0; cnt[i] <= '0;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ack  = state == S_ACK;
  assign rdy      = state == S_DONE;
  assign err_code = code_r;
  assign err      = rdy && code_r != 2'd0;
  assign bus_out  = out_r;

  for (genvar g = 0; g < NQ; g++) begin : g_flags
    assign q_full[g]  = cnt[g] == len[g];
    assign q_empty[g] = cnt[g] == '0;
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt[g] <= len[g]);
  end

  a_r1_ack_rdy_excl: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_ack && rdy));
  a_r1_rdy_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && !cmd_valid) |=> rdy);
  a_r1_rdy_single: assert property (@(posedge clk) disable iff (!rst_n) rdy |=> !rdy);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && err_code == 2'd1) |-> cnt[q_l] == $past(cnt[q_l]));
  a_r8_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && err_code == 2'd2) |-> $stable(bus_out));
  a_r5_justified: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && op_l == OP_POP && err_code == 2'd0) |-> (bus_out & ~mask_q) == '0);
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && op_l == OP_CLR) |-> &q_empty);
endmodule

// File: tb/sim_mqbuf.sv
`timescale 1ns/1ps
module sim_mqbuf;
  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = '0, cmd_q = '0;
  logic [31:0] bus_in = '0;
  logic cmd_ack, rdy, err;
  logic [1:0] err_code;
  logic [31:0] bus_out;
  logic [3:0] q_full, q_empty;

  always #2.5 clk = ~clk;

  mqbuf u0 (.clk, .rst_n, .cmd_valid, .cmd_op, .cmd_q, .bus_in, .cmd_ack, .rdy,
            .err, .err_code, .bus_out, .q_full, .q_empty);

  int checks = 0, fails = 0;
  int mlen[4], mwid[4], mhd[4], mct[4];
  logic [31:0] mq[4][64];
  logic [31:0] last_out = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  task automatic xact(input logic [1:0] op, input int q, input logic [31:0] d,
                      input int hold, input string req);
    int ec, w, tot;
    ec = 0;
    case (op)
      2'd0: begin
        w = int'(d[21:16]); tot = int'(d[15:0]);
        for (int j = 0; j < 4; j++) if (j != q) tot += mlen[j];
        if (w < 4 || w > 32 || tot > 64) ec = 3;
        else begin
          mlen[q] = int'(d[15:0]); mwid[q] = w;
          for (int j = 0; j < 4; j++) begin mhd[j] = 0; mct[j] = 0; end
        end
      end
      2'd1: if (mct[q] == mlen[q]) ec = 1;
            else begin
              mq[q][(mhd[q] + mct[q]) % mlen[q]] = d & msk(mwid[q]);
              mct[q]++;
            end
      2'd2: if (mct[q] == 0) ec = 2;
            else begin
              last_out = mq[q][mhd[q]];
              mhd[q] = (mhd[q] + 1) % mlen[q];
              mct[q]--;
            end
      default: for (int j = 0; j < 4; j++) begin mhd[j] = 0; mct[j] = 0; end
    endcase
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_q = 2'(q); bus_in = d;
    @(negedge clk);
    chk("R1 ack raised", cmd_ack, 1); chk("R1 rdy low during ack", rdy, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R1 ack held", cmd_ack, 1); chk("R1 rdy waits for release", rdy, 0);
    end
    cmd_valid = 0; bus_in = ~d;
    @(negedge clk);
    chk("R1 rdy pulse", rdy, 1); chk("R1 ack dropped", cmd_ack, 0);
    chk({req, " code"}, err_code, 32'(ec));
    chk("R12 err line", err, 32'(ec != 0));
    chk({req, " bus_out"}, bus_out, last_out);
    for (int j = 0; j < 4; j++) begin
      chk("R6 full flag", q_full[j], 32'(mct[j] == mlen[j]));
      chk("R6 empty flag", q_empty[j], 32'(mct[j] == 0));
    end
    @(negedge clk);
    chk("R1 rdy single cycle", rdy, 0); chk("R12 err low", err, 0);
  endtask

  function automatic logic [31:0] cfgw(input int l, input int w);
    return {10'd0, 6'(w), 16'(l)};
  endfunction

  task automatic finish_up;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #900000;
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_up();
  end

  initial begin
    for (int j = 0; j < 4; j++) begin mlen[j] = 0; mwid[j] = 0; mhd[j] = 0; mct[j] = 0; end
    repeat (3) @(negedge clk);
    chk("R10 ack at reset", cmd_ack, 0); chk("R10 rdy at reset", rdy, 0);
    chk("R10 all full", q_full, 4'hF); chk("R10 all empty", q_empty, 4'hF);
    rst_n = 1;
    xact(2'd1, 2, 32'h1234, 0, "R10 push unconfigured");

    for (int w = 4; w <= 32; w++) begin
      xact(2'd0, 0, cfgw(2, w), 0, "R2 config width");
      xact(2'd1, 0, 32'hFFFF_FFFF, 0, "R5 store all ones");
      xact(2'd1, 0, 32'hA5C3_5A3C ^ 32'(w * 977), 0, "R5 store pattern");
      xact(2'd2, 0, 0, 0, "R5 pop all ones");
      xact(2'd2, 0, 0, 0, "R5 pop pattern");
    end
    xact(2'd1, 0, 32'hDEAD_BEEF, 0, "R3 pre-reject store");
    xact(2'd0, 0, cfgw(2, 3), 0, "R3 width 3 rejected");
    xact(2'd0, 0, cfgw(2, 33), 0, "R3 width 33 rejected");
    xact(2'd0, 1, cfgw(63, 8), 0, "R3 too long rejected");
    xact(2'd1, 0, 32'hFFFF_0000, 0, "R3 length kept");
    xact(2'd1, 0, 32'h1, 0, "R3 overflow proves length");
    xact(2'd2, 0, 0, 0, "R3 content kept");

    xact(2'd0, 0, cfgw(3, 4), 0, "R2 config q0");
    xact(2'd0, 1, cfgw(5, 8), 0, "R2 config q1");
    xact(2'd0, 2, cfgw(1, 17), 0, "R2 config q2");
    xact(2'd0, 3, cfgw(60, 32), 0, "R3 sum 69 rejected");
    xact(2'd0, 3, cfgw(55, 32), 0, "R2 sum 64 accepted");
    xact(2'd0, 3, cfgw(7, 32), 0, "R2 config q3");

    for (int k = 0; k < 8; k++)
      for (int q = 0; q < 4; q++)
        xact(2'd1, q, 32'(k) * 32'h1357_9BDF + 32'(q), (k == 0 && q == 0) ? 3 : 0, "R7 fill");
    for (int k = 0; k < 8; k++)
      for (int q = 3; q >= 0; q--)
        xact(2'd2, q, 0, 0, "R4 R8 drain");

    for (int k = 0; k < 60; k++)
      xact((k % 3 == 2) ? 2'd2 : 2'd1, 1, 32'hC0DE_0000 + 32'(k * 31), 0, "R11 wrap");
    for (int k = 0; k < 6; k++) xact(2'd2, 1, 0, 0, "R11 wrap drain");
    for (int k = 0; k < 20; k++)
      xact(k[0] ? 2'd2 : 2'd1, 3, 32'(k) * 32'h0101_0101, 0, "R11 alternate");

    xact(2'd1, 0, 32'h7, 0, "R9 pre-clear q0");
    xact(2'd1, 2, 32'h1_2345, 0, "R9 pre-clear q2");
    xact(2'd3, 0, 0, 0, "R9 clear");
    xact(2'd2, 0, 0, 0, "R9 q0 empty after clear");
    for (int k = 0; k < 4; k++) xact(2'd1, 0, 32'(k + 9), 0, "R9 length kept");
    for (int k = 0; k < 3; k++) xact(2'd2, 0, 0, 0, "R9 width kept");
    finish_up();
  end
endmodule